// File: doc/BRIEF.md
# I2C-Controlled Stereo Routing Controller

This block is the digital control side of a stereo crosspoint: three stereo outputs, each fed by one of six stereo inputs or held silent. It listens as a write-only slave on a two-wire serial bus. SCL and SDA are sampled with a fast system clock, and the block recognises START and STOP conditions itself. A strap pin chooses between two fixed bus addresses.

Once a write to the block's own address has been acknowledged, each further byte in the transfer names one output and one input code. The block acknowledges the byte and updates that output's routing register during the acknowledge. The left and right switches of an output share one control. For each output the block drives a select code, a one-hot enable vector over the six inputs, and a mute flag. The analog switches are outside the block. The only thing it drives onto the bus is an open-drain pull-down for SDA.

Top module: `audio_route_ctrl`

## Requirements
- R1: With `addrSel` low the block answers the address byte 0x98, and with `addrSel` high it answers 0x9A (7-bit address 0x4C or 0x4D, R/W bit 0). It acknowledges that byte.
- R2: The block does not acknowledge an address byte that differs from its own address or has R/W bit 1. Data bytes that follow in the same transfer get no acknowledge and change no routing.
- R3: The acknowledge holds `sdaPullLow` at 1 for the whole ninth SCL clock. `sdaPullLow` is 0 at all other times and changes only while SCL is low.
- R4: In a data byte, bits shift in MSB first. Bits [6:5] select the output (00 is output 1, 01 is output 2, 10 is output 3). Bits [2:0] carry the input code. Bits 7, 4 and 3 have no effect.
- R5: Input codes 0 to 5 route input code+1 to the addressed output. The output's select field then equals the code, its enable row has only bit `code` set, and its mute flag is 0.
- R6: Input codes 6 (110) and 7 (111) mute the addressed output. The select field then reads 6, the enable row is all zero, and the mute flag is 1.
- R7: A data byte with output field 11 is acknowledged but changes no output.
- R8: After reset every output is muted (select 6, enables zero, mute set) and `sdaPullLow` is 0.
- R9: Any number of data bytes may follow one address, and each one updates its output before the next byte begins.
- R10: A START or STOP in the middle of a byte throws away the partial byte. After a repeated START the block expects an address byte again.
- Flat field layout used on the ports: output k (0-based) has its select code at `outSel[3k+2:3k]`, its enable row at `outEnable[6k+5:6k]` (bit i is input i+1) and its mute flag at `outMute[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock as seen on the wire |
| sdaIn | input | 1 | Bus data as seen on the wire (includes the block's own pull-down) |
| addrSel | input | 1 | Address strap: 0 selects 0x98, 1 selects 0x9A |
| sdaPullLow | output | 1 | 1 pulls SDA low through the open-drain driver |
| outSel | output | 9 | Select code per output, 3 bits each |
| outEnable | output | 18 | One-hot input enable row per output, 6 bits each |
| outMute | output | 3 | Mute flag per output |

## Verification
The bench builds the block with its default parameters: three outputs, six inputs and a two-stage synchroniser. With these values the whole byte space is small. For each strap value the bench sends all four output fields combined with all eight input codes, so every routing, both mute codes and the ignored field are each reached under both addresses. It also sets the don't-care bits in a changing pattern. It then covers the wrong-address case, a read request, a STOP and a repeated START in the middle of a byte, and the timing of the pull-down during the data and acknowledge clocks.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;
  localparam int OUT_FIELD_W = 2;
  localparam int CODE_W      = 3;
  localparam int BYTE_W      = 8;
  localparam logic [CODE_W-1:0] MUTE_CODE = 3'b110;

  typedef struct packed {
    logic                   commit;
    logic [OUT_FIELD_W-1:0] outIdx;
    logic [CODE_W-1:0]      inCode;
  } routeStrobe_t;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_ADDR_ACK,
    BUS_DATA,
    BUS_DATA_ACK,
    BUS_SKIP
  } busState_t;
endpackage

// File: rtl/i2c_route_ctrl.sv
module i2c_route_ctrl
  import audio_route_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h4C
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         addrSel,
  output logic         sdaPullLow,
  output routeStrobe_t strobe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] addrByte;

  // Input synchronisers, bus idles high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclPipe[SYNC_STAGES-1];
  assign sdaNow    = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startCond = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopCond  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign addrByte  = {ADDR_BASE | {6'b0, addrSel}, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= BUS_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      sdaPullLow <= 1'b0;
      strobe     <= '0;
    end else begin
      strobe <= '0;
      if (startCond) begin
        state      <= BUS_ADDR;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (stopCond) begin
        state      <= BUS_IDLE;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else begin
        unique case (state)
          BUS_ADDR, BUS_DATA: begin
            if (sclRise && bitCnt != LAST_BIT) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
              bitCnt   <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == LAST_BIT) begin
              if (state == BUS_ADDR) begin
                if (shiftReg == addrByte) begin
                  sdaPullLow <= 1'b1;
                  state      <= BUS_ADDR_ACK;
                end else begin
                  state <= BUS_SKIP;
                end
              end else begin
                sdaPullLow    <= 1'b1;
                state         <= BUS_DATA_ACK;
                strobe.commit <= 1'b1;
                strobe.outIdx <= shiftReg[6:5];
                strobe.inCode <= shiftReg[CODE_W-1:0];
              end
            end
          end
          BUS_ADDR_ACK, BUS_DATA_ACK: begin
            if (sclFall) begin
              sdaPullLow <= 1'b0;
              bitCnt     <= '0;
              state      <= BUS_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  sda_steady_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclNow && sclPrev) |-> $stable(sdaPullLow));

  // R1
  ack_after_full_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> ($past(sclFall) && $past(bitCnt) == LAST_BIT));

  // R10
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> (state == BUS_ADDR && bitCnt == '0 && !sdaPullLow));

  // R2
  skip_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUS_SKIP) |=> !strobe.commit);
endmodule

// File: rtl/route_regs.sv
module route_regs
  import audio_route_pkg::*;
#(
  parameter int NUM_OUT = 3,
  parameter int NUM_IN  = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  routeStrobe_t                strobe,
  output logic [NUM_OUT*CODE_W-1:0]   selFlat,
  output logic [NUM_OUT*NUM_IN-1:0]   enFlat,
  output logic [NUM_OUT-1:0]          muteVec
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [CODE_W-1:0] selReg;
    logic              hit;

    assign hit = strobe.commit && (int'(strobe.outIdx) == o);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        selReg <= MUTE_CODE;
      end else if (hit) begin
        selReg <= (int'(strobe.inCode) < NUM_IN) ? strobe.inCode : MUTE_CODE;
      end
    end

    assign selFlat[o*CODE_W +: CODE_W] = selReg;
    assign muteVec[o] = (int'(selReg) >= NUM_IN);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      assign enFlat[o*NUM_IN + i] = (selReg == CODE_W'(i));
    end

    // R5
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $countones({muteVec[o], enFlat[o*NUM_IN +: NUM_IN]}) == 1);

    // R6
    mute_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit && int'(strobe.inCode) >= NUM_IN) |=> muteVec[o]);
  end

  // R7
  unused_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && int'(strobe.outIdx) >= NUM_OUT) |=> $stable(selFlat));

  // R9
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(selFlat));
endmodule

// File: rtl/audio_route_ctrl.sv
module audio_route_ctrl
  import audio_route_pkg::*;
#(
  parameter int         NUM_OUT     = 3,
  parameter int         NUM_IN      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h4C
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic                      addrSel,
  output logic                      sdaPullLow,
  output logic [NUM_OUT*CODE_W-1:0] outSel,
  output logic [NUM_OUT*NUM_IN-1:0] outEnable,
  output logic [NUM_OUT-1:0]        outMute
);
  routeStrobe_t strobe;

  i2c_route_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_BASE  (ADDR_BASE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .addrSel   (addrSel),
    .sdaPullLow(sdaPullLow),
    .strobe    (strobe)
  );

  route_regs #(
    .NUM_OUT(NUM_OUT),
    .NUM_IN (NUM_IN)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .selFlat(outSel),
    .enFlat (outEnable),
    .muteVec(outMute)
  );

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!sdaPullLow && outMute == '1));
endmodule

// File: tb/audio_route_ctrl_bench.sv
module audio_route_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SCL_HALF   = 40;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaPullLow;
  logic sdaLine;
  logic [8:0]  outSel;
  logic [17:0] outEnable;
  logic [2:0]  outMute;

  int checks = 0;
  int errors = 0;
  int expCode [3];
  bit busyBad;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  audio_route_ctrl u_audio_route_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaPullLow(sdaPullLow), .outSel(outSel), .outEnable(outEnable), .outMute(outMute)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (SCL_HALF) @(negedge clk);
  endtask

  task automatic checkAll(input string req);
    for (int o = 0; o < 3; o++) begin
      int c = expCode[o];
      chk(req, int'(outSel[3*o +: 3]), (c < 6) ? c : 6);
      chk(req, int'(outEnable[6*o +: 6]), (c < 6) ? (1 << c) : 0);
      chk(req, int'(outMute[o]), (c < 6) ? 0 : 1);
    end
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; halfWait();
    sclM = 1'b1; halfWait();
    sdaM = 1'b0; halfWait();
    sclM = 1'b0; halfWait();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; halfWait();
    sclM = 1'b1; halfWait();
    sdaM = 1'b1; halfWait();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdaM = b[7-i]; halfWait();
      sclM = 1'b1;
      repeat (SCL_HALF/2) @(negedge clk);
      if (sdaPullLow) busyBad = 1'b1;
      repeat (SCL_HALF/2) @(negedge clk);
      sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    busyBad = 1'b0;
    sendBits(b, 8);
    sdaM = 1'b1; halfWait();
    sclM = 1'b1;
    repeat (SCL_HALF/2) @(negedge clk);
    acked = !sdaLine;
    repeat (SCL_HALF/2) @(negedge clk);
    sclM = 1'b0;
    halfWait();
    chk("R3", int'(busyBad), 0);
    chk("R3", int'(sdaPullLow), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int o = 0; o < 3; o++) expCode[o] = 6;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R8 reset state
    checkAll("R8");
    chk("R8", int'(sdaPullLow), 0);

    // R1 R4 R5 R6 R7 R9: full sweep under both straps
    for (int s = 0; s < 2; s++) begin
      addrSel = s[0];
      i2cStart();
      sendByte(8'h98 | (8'(s) << 1), ack);
      chk("R1", int'(ack), 1);
      for (int f = 0; f < 4; f++) begin
        for (int c = 0; c < 8; c++) begin
          logic [7:0] b;
          int k = f * 8 + c + s;
          b = {k[0], f[1:0], k[1], k[2], c[2:0]};
          sendByte(b, ack);
          chk("R9", int'(ack), 1);
          if (f < 3) expCode[f] = c;
          checkAll((f == 3) ? "R7" : (c >= 6) ? "R6" : "R5");
        end
      end
      i2cStop();
    end

    // set a known mixed state: out1=in2, out2=mute, out3=in6
    addrSel = 1'b0;
    i2cStart();
    sendByte(8'h98, ack);
    sendByte(8'h01, ack); expCode[0] = 1;
    sendByte(8'h26, ack); expCode[1] = 6;
    sendByte(8'h45, ack); expCode[2] = 5;
    i2cStop();
    checkAll("R4");

    // R2 wrong address
    i2cStart();
    sendByte(8'h9A, ack);
    chk("R2", int'(ack), 0);
    sendByte(8'h03, ack);
    chk("R2", int'(ack), 0);
    i2cStop();
    checkAll("R2");

    // R2 read request
    i2cStart();
    sendByte(8'h99, ack);
    chk("R2", int'(ack), 0);
    sendByte(8'h22, ack);
    chk("R2", int'(ack), 0);
    i2cStop();
    checkAll("R2");

    // R10 STOP mid-byte
    i2cStart();
    sendByte(8'h98, ack);
    chk("R10", int'(ack), 1);
    sendBits(8'h00, 4);
    i2cStop();
    checkAll("R10");

    // R10 repeated START mid-byte, then address expected again
    i2cStart();
    sendByte(8'h98, ack);
    sendBits(8'h40, 5);
    i2cStart();
    sendByte(8'h40, ack);
    chk("R10", int'(ack), 0);
    checkAll("R10");
    i2cStart();
    sendByte(8'h98, ack);
    chk("R10", int'(ack), 1);
    sendByte(8'h42, ack);
    chk("R10", int'(ack), 1);
    expCode[2] = 2;
    i2cStop();
    checkAll("R10");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule